// File: doc/BRIEF.md
# Banked Colour Palette Lookup

This block holds a 256-entry colour palette. Each entry carries an 8-bit red, an 8-bit green and an 8-bit blue component and one transparency bit. A host reaches the whole table through a small window of 32 register addresses. A bank input chooses which group of 32 entries the window covers. A half-select input chooses whether a write loads the upper or the lower nibble of each component.

Older 12-bit software only ever writes the upper half. That write also copies each nibble into the lower half, so a 4-bit component value keeps its full brightness. Newer software writes the upper half first and then the lower half to set a full 24-bit colour. A read-only input turns every host access into a read.

On the display side, an 8-bit pixel index is XORed with a mask before it addresses the table. The entry it selects appears on the RGB and transparency outputs one clock later.

Top module: `palette_lut`

## Requirements
- R1: After reset every entry holds zero. The pixel outputs `pixRgb` and `pixTransp` are zero until the first lookup of a written entry.
- R2: A host access at window address `a` with bank `b` reaches entry `b*32 + a`. Bank 0 covers entries 0–31 and bank 7 covers entries 224–255.
- R3: A write with `loHalf`=0 takes the host word as bit 15 = transparency, bits 11:8 = red nibble, bits 7:4 = green nibble and bits 3:0 = blue nibble. It stores each nibble into both the upper and the lower nibble of its component, so nibble 3 gives 0x33. It stores bit 15 as the transparency bit and ignores bits 14:12.
- R4: A write with `loHalf`=1 replaces only the lower nibble of each component, using the same bit positions as R3. The upper nibbles and the transparency bit keep their values.
- R5: A write with `loHalf`=0 followed by a write with `loHalf`=1 to the same entry leaves the full 24-bit colour that the two nibble sets describe.
- R6: While `readOnly` is 1, a host write leaves the table unchanged.
- R7: The pixel lookup addresses entry `pixIdx ^ xorMask`.
- R8: The lookup has one clock of latency. `pixRgb` is {red, green, blue}, with red in bits 23:16. `pixTransp` equals the transparency bit of the selected entry.
- R9: When a host write and a pixel lookup hit the same entry in the same cycle, the pixel outputs show the value the entry held before the write.
- R10: `hostRdata` shows the entry at the current bank and window address. With `loHalf`=0 it shows the transparency bit in bit 15 and the upper nibbles in bits 11:0. With `loHalf`=1 it shows the lower nibbles in bits 11:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe |
| hostWr | input | 1 | Access is a write when 1 |
| hostAddr | input | 5 | Window address within the bank |
| hostWdata | input | 16 | Host write word |
| hostRdata | output | 16 | Host read word |
| bankSel | input | 3 | Bank of 32 entries reached by the window |
| loHalf | input | 1 | Select lower nibbles when 1, upper nibbles when 0 |
| readOnly | input | 1 | Block all host writes when 1 |
| xorMask | input | 8 | Mask XORed into the pixel index |
| pixIdx | input | 8 | Pixel colour index |
| pixRgb | output | 24 | Looked-up colour {red, green, blue} |
| pixTransp | output | 1 | Looked-up transparency bit |

## Verification
The bench uses the default parameters: 3 bank bits, 5 window bits and 4-bit nibbles. At that size a full sweep is cheap, so every one of the 256 entries is written through all eight banks. Each entry is then read back in both halves and looked up on the pixel side with a zero mask and with a non-trivial mask. The expected colours come from simple arithmetic on the entry number. Together these sweeps cover the nibble duplication, the ordering of the two halves, the read-only blocking of a whole bank and the same-cycle write-versus-lookup case.

// File: rtl/palette_pkg.sv
package palette_pkg;
  // Strobes passed from the control module to the storage datapath
  typedef struct packed {
    logic wrHi;   // write upper nibbles (with lower-nibble copy) and transparency
    logic wrLo;   // write lower nibbles only
  } palStrobe_t;

  localparam int HOST_W = 16;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int WIN_W  = 5,
  parameter int NIB_W  = 4,
  localparam int IDX_W = BANK_W + WIN_W
) (
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [WIN_W-1:0]  hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              loHalf,
  input  logic              readOnly,
  output palStrobe_t        stb,
  output logic [IDX_W-1:0]  hostEntry,
  output logic [NIB_W-1:0]  wrRed,
  output logic [NIB_W-1:0]  wrGreen,
  output logic [NIB_W-1:0]  wrBlue,
  output logic              wrTransp
);
  logic doWrite;

  always_comb begin
    doWrite   = hostSel && hostWr && !readOnly;
    stb.wrHi  = doWrite && !loHalf;
    stb.wrLo  = doWrite && loHalf;
    hostEntry = {bankSel, hostAddr};
    wrRed     = hostWdata[3*NIB_W-1:2*NIB_W];
    wrGreen   = hostWdata[2*NIB_W-1:NIB_W];
    wrBlue    = hostWdata[NIB_W-1:0];
    wrTransp  = hostWdata[HOST_W-1];
  end
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NIB_W = 4,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int COMP_W  = 2 * NIB_W,
  localparam int PAD_W   = HOST_W - 1 - 3 * NIB_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  palStrobe_t          stb,
  input  logic [IDX_W-1:0]    hostEntry,
  input  logic [NIB_W-1:0]    wrRed,
  input  logic [NIB_W-1:0]    wrGreen,
  input  logic [NIB_W-1:0]    wrBlue,
  input  logic                wrTransp,
  input  logic                loHalf,
  input  logic [IDX_W-1:0]    pixIdx,
  input  logic [IDX_W-1:0]    xorMask,
  output logic [HOST_W-1:0]   hostRdata,
  output logic [3*COMP_W-1:0] pixRgb,
  output logic                pixTransp
);
  logic [NIB_W-1:0] redHi   [ENTRIES];
  logic [NIB_W-1:0] redLo   [ENTRIES];
  logic [NIB_W-1:0] greenHi [ENTRIES];
  logic [NIB_W-1:0] greenLo [ENTRIES];
  logic [NIB_W-1:0] blueHi  [ENTRIES];
  logic [NIB_W-1:0] blueLo  [ENTRIES];
  logic             transp  [ENTRIES];

  logic [IDX_W-1:0] lookIdx;

  // Table storage; the upper-half write also refreshes the lower half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        redHi[i]   <= '0;
        redLo[i]   <= '0;
        greenHi[i] <= '0;
        greenLo[i] <= '0;
        blueHi[i]  <= '0;
        blueLo[i]  <= '0;
        transp[i]  <= 1'b0;
      end
    end else if (stb.wrHi) begin
      redHi[hostEntry]   <= wrRed;
      redLo[hostEntry]   <= wrRed;
      greenHi[hostEntry] <= wrGreen;
      greenLo[hostEntry] <= wrGreen;
      blueHi[hostEntry]  <= wrBlue;
      blueLo[hostEntry]  <= wrBlue;
      transp[hostEntry]  <= wrTransp;
    end else if (stb.wrLo) begin
      redLo[hostEntry]   <= wrRed;
      greenLo[hostEntry] <= wrGreen;
      blueLo[hostEntry]  <= wrBlue;
    end
  end

  // Host read-back in the write layout
  always_comb begin
    if (loHalf)
      hostRdata = {1'b0, {PAD_W{1'b0}}, redLo[hostEntry], greenLo[hostEntry], blueLo[hostEntry]};
    else
      hostRdata = {transp[hostEntry], {PAD_W{1'b0}}, redHi[hostEntry], greenHi[hostEntry], blueHi[hostEntry]};
  end

  // Pixel lookup: remapped index, one register stage
  assign lookIdx = pixIdx ^ xorMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixRgb    <= '0;
      pixTransp <= 1'b0;
    end else begin
      pixRgb    <= {redHi[lookIdx], redLo[lookIdx], greenHi[lookIdx], greenLo[lookIdx],
                    blueHi[lookIdx], blueLo[lookIdx]};
      pixTransp <= transp[lookIdx];
    end
  end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int WIN_W  = 5,
  parameter int NIB_W  = 4,
  localparam int IDX_W = BANK_W + WIN_W,
  localparam int RGB_W = 6 * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [WIN_W-1:0]  hostAddr,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              loHalf,
  input  logic              readOnly,
  input  logic [IDX_W-1:0]  xorMask,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [RGB_W-1:0]  pixRgb,
  output logic              pixTransp
);
  palStrobe_t       stb;
  logic [IDX_W-1:0] hostEntry;
  logic [NIB_W-1:0] wrRed, wrGreen, wrBlue;
  logic             wrTransp;

  palette_ctrl #(.BANK_W(BANK_W), .WIN_W(WIN_W), .NIB_W(NIB_W)) u_ctrl (
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .bankSel(bankSel), .loHalf(loHalf), .readOnly(readOnly),
    .stb(stb), .hostEntry(hostEntry),
    .wrRed(wrRed), .wrGreen(wrGreen), .wrBlue(wrBlue), .wrTransp(wrTransp)
  );

  palette_store #(.IDX_W(IDX_W), .NIB_W(NIB_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .hostEntry(hostEntry),
    .wrRed(wrRed), .wrGreen(wrGreen), .wrBlue(wrBlue), .wrTransp(wrTransp),
    .loHalf(loHalf), .pixIdx(pixIdx), .xorMask(xorMask),
    .hostRdata(hostRdata), .pixRgb(pixRgb), .pixTransp(pixTransp)
  );
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
  import palette_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input palStrobe_t         stb,
  input logic               hostSel,
  input logic               hostWr,
  input logic               readOnly,
  input logic               loHalf,
  input logic [IDX_W-1:0]   pixIdx,
  input logic [IDX_W-1:0]   xorMask,
  input logic [HOST_W-1:0]  hostRdata,
  input logic [6*NIB_W-1:0] pixRgb,
  input logic               pixTransp
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pixRgb == '0 && !pixTransp));

  // R6
  ro_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    readOnly |-> !(stb.wrHi || stb.wrLo));

  // R3
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrHi || stb.wrLo) |-> (hostSel && hostWr));

  // R4
  half_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrHi, stb.wrLo}));

  // R10
  lo_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    loHalf |-> (hostRdata[HOST_W-1:3*NIB_W] == '0));

  // R10
  hi_read_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loHalf |-> (hostRdata[HOST_W-2:3*NIB_W] == '0));

  // R8
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && !$past(stb.wrHi, 2) && !$past(stb.wrLo, 2) &&
     $past(pixIdx) == $past(pixIdx, 2) && $past(xorMask) == $past(xorMask, 2))
    |-> ($stable(pixRgb) && $stable(pixTransp)));
endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .hostSel(hostSel), .hostWr(hostWr),
  .readOnly(readOnly), .loHalf(loHalf), .pixIdx(pixIdx), .xorMask(xorMask),
  .hostRdata(hostRdata), .pixRgb(pixRgb), .pixTransp(pixTransp)
);

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0, loHalf = 1'b0, readOnly = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic [2:0]  bankSel = '0;
  logic [7:0]  xorMask = '0, pixIdx = '0;
  logic [23:0] pixRgb;
  logic        pixTransp;

  int checks = 0;
  int fails = 0;
  logic [23:0] expRgb [256];
  logic        expT   [256];

  always #5 clk = ~clk;

  palette_lut dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .bankSel(bankSel), .loHalf(loHalf),
    .readOnly(readOnly), .xorMask(xorMask), .pixIdx(pixIdx), .pixRgb(pixRgb),
    .pixTransp(pixTransp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Upper-half word for entry e; bits 14:12 set to test that they are ignored
  function automatic logic [15:0] hiWord(input int e);
    logic [7:0] v = e[7:0];
    return {v[0] ^ v[5], 3'b111, v[3:0], v[7:4], v[3:0] ^ v[7:4]};
  endfunction

  function automatic logic [15:0] loWord(input int e);
    logic [7:0] v = e[7:0];
    return {1'b1, 3'b101, v[7:4] + 4'd1, ~v[3:0], v[6:3]};
  endfunction

  task automatic hostWrite(input int e, input logic lo, input logic [15:0] d);
    @(negedge clk);
    bankSel = e[7:5]; hostAddr = e[4:0]; loHalf = lo; hostWdata = d;
    hostSel = 1'b1; hostWr = 1'b1;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input int e, input logic lo, output logic [15:0] d);
    bankSel = e[7:5]; hostAddr = e[4:0]; loHalf = lo;
    #1 d = hostRdata;
  endtask

  task automatic pixCheck(input int idx, input logic [7:0] m, input string req);
    @(negedge clk);
    pixIdx = idx[7:0]; xorMask = m;
    @(negedge clk);
    check(req, {8'h0, pixRgb}, {8'h0, expRgb[idx[7:0] ^ m]});
    check(req, {31'h0, pixTransp}, {31'h0, expT[idx[7:0] ^ m]});
  endtask

  function automatic void modelWrite(input int e, input logic lo, input logic [15:0] d);
    if (!lo) begin
      expRgb[e] = {d[11:8], d[11:8], d[7:4], d[7:4], d[3:0], d[3:0]};
      expT[e]   = d[15];
    end else begin
      expRgb[e][19:16] = d[11:8];
      expRgb[e][11:8]  = d[7:4];
      expRgb[e][3:0]   = d[3:0];
    end
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int i = 0; i < 256; i++) begin expRgb[i] = '0; expT[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1 pix", {8'h0, pixRgb}, 32'h0);
    check("R1 transp", {31'h0, pixTransp}, 32'h0);
    for (int e = 0; e < 256; e += 37) begin
      hostRead(e, 1'b0, rd); check("R1 host", {16'h0, rd}, 32'h0);
    end

    // R2, R3: upper-half write of every entry through all banks
    for (int e = 0; e < 256; e++) begin
      hostWrite(e, 1'b0, hiWord(e)); modelWrite(e, 1'b0, hiWord(e));
    end
    for (int e = 0; e < 256; e++) begin
      hostRead(e, 1'b0, rd);
      check("R2 R3 R10 hi read", {16'h0, rd}, {16'h0, hiWord(e) & 16'h8fff});
      hostRead(e, 1'b1, rd);
      check("R3 R10 dup lo read", {16'h0, rd}, {20'h0, hiWord(e)[11:0]});
    end
    // R7, R8: pixel sweep with two masks
    for (int e = 0; e < 256; e++) pixCheck(e, 8'h00, "R8 lookup");
    for (int e = 0; e < 256; e++) pixCheck(e, 8'hA5, "R7 xor");

    // R6: read-only blocks writes to bank 3
    @(negedge clk); readOnly = 1'b1;
    for (int e = 96; e < 128; e++) begin
      hostWrite(e, 1'b0, 16'h0abc);
      hostWrite(e, 1'b1, 16'h0123);
    end
    @(negedge clk); readOnly = 1'b0;
    for (int e = 96; e < 128; e++) pixCheck(e, 8'h00, "R6 ro");

    // R4, R5: lower-half writes complete 24-bit colours
    for (int e = 0; e < 256; e++) begin
      hostWrite(e, 1'b1, loWord(e)); modelWrite(e, 1'b1, loWord(e));
    end
    for (int e = 0; e < 256; e++) pixCheck(e, 8'h3C, "R4 R5 full");
    for (int e = 0; e < 256; e += 5) begin
      hostRead(e, 1'b1, rd);
      check("R10 lo read", {16'h0, rd}, {20'h0, loWord(e)[11:0]});
      hostRead(e, 1'b0, rd);
      check("R4 hi kept", {16'h0, rd}, {16'h0, hiWord(e) & 16'h8fff});
    end

    // R9: same-cycle write and lookup return old value, then new
    for (int e = 10; e < 14; e++) begin
      logic [23:0] oldRgb;
      logic        oldT;
      oldRgb = expRgb[e]; oldT = expT[e];
      @(negedge clk);
      pixIdx = e[7:0]; xorMask = 8'h00;
      bankSel = e[7:5]; hostAddr = e[4:0]; loHalf = 1'b0;
      hostWdata = 16'h8f0f ^ {8'h0, e[7:0]}; hostSel = 1'b1; hostWr = 1'b1;
      @(negedge clk);
      hostSel = 1'b0; hostWr = 1'b0;
      check("R9 old rgb", {8'h0, pixRgb}, {8'h0, oldRgb});
      check("R9 old t", {31'h0, pixTransp}, {31'h0, oldT});
      modelWrite(e, 1'b0, 16'h8f0f ^ {8'h0, e[7:0]});
      @(negedge clk);
      check("R9 new rgb", {8'h0, pixRgb}, {8'h0, expRgb[e]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule